// File: doc/BRIEF.md
# Register-Mapped GCD Accelerator

This peripheral finds the greatest common divisor of two unsigned operands behind a small synchronous register port. Software stores the first operand in a plain holding register. It then writes the second operand, and that write starts the computation. While the engine iterates, software polls a status word. When the status shows a result is waiting, software reads the result register. That read hands the result back and frees the engine for the next pair.

Inside, a three-state engine (idle, run, done) takes operands through a valid/ready handshake. It reduces them by repeated subtraction and holds the answer until the result read acknowledges it. A `busy` pin is high whenever the engine is not idle.

The register window spans 4 KiB starting at a base address set by a parameter. Offsets are matched exactly within that window.

Top module: `gcd_periph`

## Requirements
- R1: After synchronous active-high reset, `busy` is 0 and a status read returns 2 (input-ready set, result-valid clear).
- R2: The status word at offset 0x000 has input-ready in bit 1 and result-valid in bit 0, with all upper bits zero. The two bits are never set together, and while the engine runs both read 0.
- R3: A write to offset 0x004 stores operand x and starts nothing: `busy` stays 0.
- R4: A write to offset 0x008 while input-ready is set launches the engine with the stored x and the written y. `busy` is high from the next cycle until the result is read.
- R5: The result equals the greatest common divisor of x and y. If one operand is zero, the result is the other operand. If both are zero, the result is 0.
- R6: A read of offset 0x00C while result-valid is set returns the result and consumes it. After that read, status returns 2 and `busy` is 0.
- R7: A read of offset 0x00C while result-valid is clear returns 0 and leaves the engine state unchanged.
- R8: A write to offset 0x008 while input-ready is clear is dropped, and the running computation is not disturbed.
- R9: Reads of offsets 0x004, 0x008 and any unmapped offset return 0. Writes to offsets 0x000, 0x00C and unmapped offsets change nothing.
- R10: Accesses whose address lies outside the 4 KiB window at the base address have no effect, and reads of such addresses return 0.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and is 0 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | W | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | W | Registered read data |
| busy | output | 1 | High while the engine is not idle |

## Verification
The assertions assume that reset is held high from time zero until after the first clock edge. They also assume that no read strobe is raised during reset, because the check on idle read data looks one cycle back. The bench asserts reset for several cycles before any access. It drives at most one strobe per cycle, and only for a single cycle. It also waits for result-valid before a consuming read, except where it deliberately reads early to test R7.

// File: rtl/gcdp_pkg.sv
package gcdp_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;

  localparam int WIN_BITS = 12;

  localparam logic [WIN_BITS-1:0] OFS_STAT = 12'h000;
  localparam logic [WIN_BITS-1:0] OFS_OPX  = 12'h004;
  localparam logic [WIN_BITS-1:0] OFS_OPY  = 12'h008;
  localparam logic [WIN_BITS-1:0] OFS_RES  = 12'h00C;
endpackage

// File: rtl/gcdp_engine.sv
module gcdp_engine
  import gcdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opx,
  input  logic [W-1:0] opy,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         busy
);

  eng_state_e   state;
  logic [W-1:0] va, vb;

  // reduction ends when either value is zero or both agree
  function automatic logic settled(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a == '0) || (b == '0) || (a == b);
  endfunction

  // answer once settled: the nonzero value, or the other when one is zero
  function automatic logic [W-1:0] answer(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a == '0) ? b : a;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ENG_IDLE;
      va    <= '0;
      vb    <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (in_valid) begin
            va    <= opx;
            vb    <= opy;
            state <= ENG_RUN;
          end
        end
        ENG_RUN: begin
          if (settled(va, vb)) begin
            va    <= answer(va, vb);
            state <= ENG_DONE;
          end else if (va > vb) begin
            va <= va - vb;
          end else begin
            vb <= vb - va;
          end
        end
        ENG_DONE: begin
          if (out_ready) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ENG_IDLE);
  assign out_valid = (state == ENG_DONE);
  assign result    = va;
  assign busy      = (state != ENG_IDLE);

endmodule

// File: rtl/gcdp_regif.sv
module gcdp_regif
  import gcdp_pkg::*;
#(
  parameter int              W    = 32,
  parameter int              AW   = 32,
  parameter logic [AW-1:0]   BASE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_rd,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  opx,
  output logic [W-1:0]  opy,
  output logic          launch,
  output logic          pop,
  output logic          y_wr_hit,
  input  logic          eng_in_ready,
  input  logic          eng_out_valid,
  input  logic [W-1:0]  eng_result
);

  localparam int TAG_W = AW - WIN_BITS;

  logic                in_win;
  logic [WIN_BITS-1:0] ofs;
  logic [W-1:0]        rd_val;
  logic [W-1:0]        x_q;

  assign in_win = (bus_addr[AW-1:WIN_BITS] == BASE[AW-1:WIN_BITS]);
  assign ofs    = bus_addr[WIN_BITS-1:0];

  // named access events
  assign y_wr_hit = bus_wr && in_win && (ofs == OFS_OPY);
  assign launch   = y_wr_hit && eng_in_ready;
  assign pop      = bus_rd && in_win && (ofs == OFS_RES) && eng_out_valid;
  assign opx      = x_q;
  assign opy      = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) x_q <= '0;
    else if (bus_wr && in_win && (ofs == OFS_OPX)) x_q <= bus_wdata;
  end

  always_comb begin
    rd_val = '0;
    if (in_win) begin
      unique case (ofs)
        OFS_STAT: rd_val = {{(W-2){1'b0}}, eng_in_ready, eng_out_valid};
        OFS_RES:  rd_val = eng_out_valid ? eng_result : '0;
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  if (TAG_W < 1) begin : g_bad_aw
    initial $display("gcdp_regif: AW must exceed the window bits");
  end

endmodule

// File: rtl/gcd_periph.sv
module gcd_periph
  import gcdp_pkg::*;
#(
  parameter int            W    = 32,
  parameter int            AW   = 32,
  parameter logic [AW-1:0] BASE = 32'h1000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_rd,
  output logic [W-1:0]  bus_rdata,
  output logic          busy
);

  logic [W-1:0] opx, opy, eng_result;
  logic         launch, pop, y_wr_hit;
  logic         eng_in_ready, eng_out_valid;

  gcdp_regif #(.W(W), .AW(AW), .BASE(BASE)) u_regif (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .opx          (opx),
    .opy          (opy),
    .launch       (launch),
    .pop          (pop),
    .y_wr_hit     (y_wr_hit),
    .eng_in_ready (eng_in_ready),
    .eng_out_valid(eng_out_valid),
    .eng_result   (eng_result)
  );

  gcdp_engine #(.W(W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .opx      (opx),
    .opy      (opy),
    .in_valid (launch),
    .in_ready (eng_in_ready),
    .out_valid(eng_out_valid),
    .out_ready(pop),
    .result   (eng_result),
    .busy     (busy)
  );

endmodule

// File: rtl/gcdp_chk.sv
module gcdp_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         launch,
  input logic         pop,
  input logic         y_wr_hit,
  input logic         in_ready,
  input logic         out_valid,
  input logic         busy,
  input logic         bus_rd,
  input logic [W-1:0] bus_rdata
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid && !busy));

  // R2
  status_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R4
  busy_after_launch_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy && !in_ready));

  // R6
  pop_frees_chk: assert property (@(posedge clk) disable iff (rst)
    pop |=> (!out_valid && in_ready && !busy));

  // R7
  valid_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !pop) |=> out_valid);

  // R8
  drop_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (y_wr_hit && busy) |-> !launch);

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0));

endmodule

bind gcd_periph gcdp_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .launch   (launch),
  .pop      (pop),
  .y_wr_hit (y_wr_hit),
  .in_ready (eng_in_ready),
  .out_valid(eng_out_valid),
  .busy     (busy),
  .bus_rd   (bus_rd),
  .bus_rdata(bus_rdata)
);

// File: tb/sim_gcd_periph.sv
module sim_gcd_periph;
  localparam int            W    = 8;
  localparam int            AW   = 16;
  localparam logic [AW-1:0] BASE = 16'h3000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [W-1:0]  bus_rdata;
  logic          busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gcd_periph #(.W(W), .AW(AW), .BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .busy(busy)
  );

  function automatic int ref_gcd(input int a, input int b);
    int p = a, q = b;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input int d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d[W-1:0]; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic wait_valid(output int ok);
    int s;
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(BASE + 16'h000, s);
      if (s == 1) begin ok = 1; break; end
    end
  endtask

  task automatic run_case(input int x, input int y);
    int ok, r, s;
    wr(BASE + 16'h004, x);
    wr(BASE + 16'h008, y);
    wait_valid(ok);
    chk("R5 completion", ok, 1);
    rd(BASE + 16'h00C, r);
    chk("R5 result", r, ref_gcd(x, y));
    rd(BASE + 16'h000, s);
    chk("R6 status after pop", s, 2);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, ok;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    rd(BASE + 16'h000, v);
    chk("R1 status", v, 2);
    // R7 early result read
    rd(BASE + 16'h00C, v);
    chk("R7 result idle", v, 0);

    // R3 operand x write starts nothing
    wr(BASE + 16'h004, 255);
    repeat (3) @(negedge clk);
    chk("R3 busy", int'(busy), 0);
    rd(BASE + 16'h000, v);
    chk("R3 status", v, 2);

    // R4 launch with long run 255,1
    wr(BASE + 16'h008, 1);
    chk("R4 busy", int'(busy), 1);
    rd(BASE + 16'h000, v);
    chk("R2 status running", v, 0);
    // R8 dropped second launch
    wr(BASE + 16'h004, 6);
    wr(BASE + 16'h008, 4);
    // R7 read while running
    rd(BASE + 16'h00C, v);
    chk("R7 result running", v, 0);
    wait_valid(ok);
    chk("R2 valid seen", ok, 1);
    chk("R4 busy while done", int'(busy), 1);
    // R9 writes to read-only offsets ignored
    wr(BASE + 16'h00C, 77);
    wr(BASE + 16'h000, 3);
    wr(BASE + 16'h020, 9);
    rd(BASE + 16'h000, v);
    chk("R9 status unchanged", v, 1);
    rd(BASE + 16'h00C, v);
    chk("R8 result of first pair", v, 1);
    chk("R6 busy after pop", int'(busy), 0);
    rd(BASE + 16'h000, v);
    chk("R6 status after pop", v, 2);

    // R9 write-only and unmapped reads return 0
    rd(BASE + 16'h004, v);
    chk("R9 read x", v, 0);
    rd(BASE + 16'h008, v);
    chk("R9 read y", v, 0);
    rd(BASE + 16'h010, v);
    chk("R9 read unmapped", v, 0);
    wr(BASE + 16'h000, 1);
    chk("R9 status write no launch", int'(busy), 0);

    // R10 out-of-window accesses
    wr(BASE + 16'h004, 12);
    wr(16'h4004, 99);
    wr(16'h4008, 5);
    chk("R10 no launch", int'(busy), 0);
    rd(16'h4000, v);
    chk("R10 read outside", v, 0);
    wr(BASE + 16'h008, 8);
    wait_valid(ok);
    rd(BASE + 16'h00C, v);
    chk("R10 x kept", v, 4);

    // R11 rdata returns to zero after the read cycle
    rd(BASE + 16'h000, v);
    chk("R11 read data", v, 2);
    @(negedge clk);
    chk("R11 idle zero", int'(bus_rdata), 0);

    // R5 sweep over small operands, zeros included
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run_case(x, y);
    run_case(255, 1);
    run_case(200, 255);
    run_case(128, 96);
    run_case(0, 255);
    run_case(254, 127);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule